// File: doc/BRIEF.md
# Framing Bit Error Reframe Monitor

This block sits behind a T1 frame aligner and judges the quality of the received framing pattern once alignment has been declared. Each frame it receives one framing bit together with the value that bit should have, a flag telling terminal (Ft) from signalling (Fs) positions, and the frame's number within the superframe. A bit that counts under the current mode and differs from its expected value is an error. Errors feed a saturating counter that software reads and clears. They also feed a short history of checked bits. When enough errors fall inside the selected window, the block asks the aligner to start a new frame search.

Software can also force a frame search directly. In D4 and SLC96 formats it can request multiframe resynchronisation alone. While that request is open, signalling is held frozen until the aligner reports multiframe sync again. After any reframe request the block stops judging bits until the aligner reports sync anew.

Top module: `fbe_reframe_mon`

## Requirements
- R1: After reset, `refr_req`, `mf_refr_req` and `sig_freeze` are low and `err_cnt` is zero.
- R2: A frame strobe in cycle n affects outputs from the clock edge that ends cycle n. With `win_sel` = 2'b00, a `refr_req` pulse is raised when the newest checked bit is errored and 2 of the last 4 checked bits are errored.
- R3: With `win_sel` = 2'b01, the window is the last 5 checked bits. Two errors 4 checked bits apart trigger a reframe, and two errors 5 apart do not.
- R4: With `win_sel` = 2'b10, the window is the last 6 checked bits. Two errors 5 checked bits apart trigger a reframe.
- R5: With `win_sel` = 2'b11, errors never cause `refr_req`, but every errored checked bit is still counted.
- R6: Ft bits (`fbit_is_fs` = 0) are checked in every format. In D4 (`fmt_esf` = 0 and `fmt_slc` = 0), Fs bits are checked only when `fs_incl` = 1. An Fs bit with `frame_num` = 12 is checked only when `sec_yel` = 0.
- R7: In ESF (`fmt_esf` = 1) or SLC96 (`fmt_slc` = 1), Fs bits are never checked or counted, whatever `fs_incl` is.
- R8: A high `host_refr` in a cycle makes `refr_req` high in the next cycle, whatever the error history.
- R9: `refr_req` lasts one cycle unless `host_refr` is held. After any reframe, the error history is empty and no framing bit is checked until `in_sync` rises again. Checking resumes from the cycle after the rising edge is seen.
- R10: `err_cnt` increments by one per errored checked bit and holds at its maximum value.
- R11: A high `cnt_clr` makes `err_cnt` zero in the next cycle, even if an errored bit arrives in the same cycle.
- R12: A high `host_mfrefr` while `fmt_esf` = 0 gives a one-cycle `mf_refr_req` and sets `sig_freeze` in the next cycle. `sig_freeze` stays high until `mf_sync` is high, and `refr_req` is unaffected. While `fmt_esf` = 1, `host_mfrefr` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_sync | input | 1 | Frame aligner reports terminal frame sync |
| frm_stb | input | 1 | One-cycle strobe: framing bit of a frame is present |
| fbit_rx | input | 1 | Received framing bit |
| fbit_exp | input | 1 | Expected value of the framing bit |
| fbit_is_fs | input | 1 | 1 = signalling framing bit (Fs), 0 = terminal (Ft) |
| frame_num | input | 4 | Frame number within the superframe, 1..12 |
| fmt_esf | input | 1 | Extended superframe format selected |
| fmt_slc | input | 1 | SLC96 format selected |
| fs_incl | input | 1 | Count Fs errors in D4 format |
| sec_yel | input | 1 | Secondary yellow control; high excludes the frame-12 Fs bit |
| win_sel | input | 2 | Error window: 00 = 2/4, 01 = 2/5, 10 = 2/6, 11 = off |
| host_refr | input | 1 | Force a terminal frame reframe |
| host_mfrefr | input | 1 | Request multiframe reframe only |
| mf_sync | input | 1 | Aligner reports multiframe sync |
| cnt_clr | input | 1 | Clear the error counter |
| refr_req | output | 1 | One-cycle terminal frame reframe request |
| err_cnt | output | CNT_W | Saturating framing bit error count |
| mf_refr_req | output | 1 | One-cycle multiframe reframe request |
| sig_freeze | output | 1 | Hold signalling bits while multiframe sync is pending |

## Verification
The bench builds the block with `CNT_W` = 3, so the counter reaches its ceiling of 7 after seven errors. That makes saturation, and clearing at the ceiling, reachable within a few dozen frames. Because the error window is fixed at six entries whatever the counter width, the narrow counter does not shorten any window sequence.

// File: rtl/fbe_reframe_mon.sv
module fbe_reframe_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             frm_stb,
  input  logic             fbit_rx,
  input  logic             fbit_exp,
  input  logic             fbit_is_fs,
  input  logic [3:0]       frame_num,
  input  logic             fmt_esf,
  input  logic             fmt_slc,
  input  logic             fs_incl,
  input  logic             sec_yel,
  input  logic [1:0]       win_sel,
  input  logic             host_refr,
  input  logic             host_mfrefr,
  input  logic             mf_sync,
  input  logic             cnt_clr,
  output logic             refr_req,
  output logic [CNT_W-1:0] err_cnt,
  output logic             mf_refr_req,
  output logic             sig_freeze
);
  localparam int         WIN     = 6;
  localparam int         HITS    = 2;
  localparam logic [1:0] SEL_OFF = 2'b11;

  logic [WIN-1:0] win_q;
  logic [WIN-1:0] mask;
  logic           armed_q, sync_q;

  wire d4    = !fmt_esf && !fmt_slc;
  wire fs_ok = fs_incl && d4 && !(frame_num == 4'd12 && sec_yel);
  wire chk   = frm_stb && in_sync && armed_q && (!fbit_is_fs || fs_ok);
  wire bad   = chk && (fbit_rx != fbit_exp);

  wire [WIN-1:0] win_nx = {win_q[WIN-2:0], bad};

  always_comb begin
    case (win_sel)
      2'b00:   mask = 6'b001111;
      2'b01:   mask = 6'b011111;
      default: mask = 6'b111111;
    endcase
  end

  wire auto_rf = bad && (win_sel != SEL_OFF) && ($countones(win_nx & mask) >= HITS);
  wire fire    = auto_rf || host_refr;
  wire mf_go   = host_mfrefr && !fmt_esf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= '0;
      armed_q     <= 1'b0;
      sync_q      <= 1'b0;
      refr_req    <= 1'b0;
      err_cnt     <= '0;
      mf_refr_req <= 1'b0;
      sig_freeze  <= 1'b0;
    end else begin
      sync_q   <= in_sync;
      refr_req <= fire;
      if (fire) begin
        armed_q <= 1'b0;
        win_q   <= '0;
      end else begin
        if (in_sync && !sync_q) armed_q <= 1'b1;
        if (chk) win_q <= win_nx;
      end
      if (cnt_clr)                 err_cnt <= '0;
      else if (bad && ~&err_cnt)   err_cnt <= err_cnt + 1'b1;
      mf_refr_req <= mf_go;
      if (mf_go)        sig_freeze <= 1'b1;
      else if (mf_sync) sig_freeze <= 1'b0;
    end
  end
endmodule

module fbe_reframe_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fbit_is_fs,
  input logic             fmt_esf,
  input logic             fmt_slc,
  input logic [1:0]       win_sel,
  input logic             host_refr,
  input logic             mf_sync,
  input logic             cnt_clr,
  input logic             refr_req,
  input logic [CNT_W-1:0] err_cnt,
  input logic             mf_refr_req,
  input logic             sig_freeze
);
  a_r8_host_forces: assert property (@(posedge clk) disable iff (!rst_n)
    host_refr |=> refr_req);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refr_req |=> (!refr_req || $past(host_refr)));
  a_r5_window_off: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel == 2'b11 && !host_refr) |=> !refr_req);
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_cnt && !cnt_clr) |=> &err_cnt);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (err_cnt == '0));
  a_r7_slc_fs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_slc && fbit_is_fs && !cnt_clr) |=> $stable(err_cnt));
  a_r12_esf_no_mf: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_esf |=> !mf_refr_req);
  a_r12_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_freeze && !mf_sync) |=> sig_freeze);
  a_r12_mf_sets_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    mf_refr_req |-> sig_freeze);
endmodule

bind fbe_reframe_mon fbe_reframe_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fbit_is_fs(fbit_is_fs), .fmt_esf(fmt_esf),
  .fmt_slc(fmt_slc), .win_sel(win_sel), .host_refr(host_refr),
  .mf_sync(mf_sync), .cnt_clr(cnt_clr), .refr_req(refr_req),
  .err_cnt(err_cnt), .mf_refr_req(mf_refr_req), .sig_freeze(sig_freeze)
);

// File: tb/test_fbe_reframe_mon.sv
`timescale 1ns/1ps
module test_fbe_reframe_mon;
  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_sync = 0, frm_stb = 0, fbit_rx = 0, fbit_exp = 0, fbit_is_fs = 0;
  logic [3:0] frame_num = 4'd1;
  logic fmt_esf = 0, fmt_slc = 0, fs_incl = 0, sec_yel = 0;
  logic [1:0] win_sel = 2'b00;
  logic host_refr = 0, host_mfrefr = 0, mf_sync = 0, cnt_clr = 0;
  logic refr_req, mf_refr_req, sig_freeze;
  logic [CNT_W-1:0] err_cnt;

  always #5 clk = ~clk;

  fbe_reframe_mon #(.CNT_W(CNT_W)) i_fbe_reframe_mon (.*);

  typedef struct { bit refr; int cnt; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, exp_cnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit e, input bit fs, input int fn, input bit counted,
                      input bit refr, input bit clr, input string tag);
    item_t it;
    @(negedge clk);
    frm_stb = 1; fbit_is_fs = fs; frame_num = 4'(fn);
    fbit_exp = fn[0]; fbit_rx = fn[0] ^ e; cnt_clr = clr;
    if (clr) exp_cnt = 0;
    else if (e && counted && exp_cnt < CMAX) exp_cnt++;
    it.refr = refr; it.cnt = exp_cnt; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    frm_stb = 0; cnt_clr = 0;
  endtask

  initial begin : monitor
    item_t it;
    bit s;
    forever begin
      @(posedge clk); s = frm_stb;
      @(negedge clk);
      if (s) begin
        if (sb.size() == 0) check(0, "scoreboard empty", 0, 1);
        else begin
          it = sb.pop_front();
          check(refr_req == it.refr, {it.tag, " refr_req"}, refr_req, it.refr);
          check(err_cnt == it.cnt, {it.tag, " err_cnt"}, err_cnt, it.cnt);
        end
      end
    end
  end

  task automatic resync();
    @(negedge clk); in_sync = 0;
    @(negedge clk); in_sync = 1;
    @(negedge clk);
  endtask

  task automatic host_reframe(input string tag);
    @(negedge clk); host_refr = 1;
    @(negedge clk); host_refr = 0;
    check(refr_req == 1, tag, refr_req, 1);
    @(negedge clk);
    check(refr_req == 0, {tag, " pulse ends"}, refr_req, 0);
  endtask

  initial begin : driver
    #23 ;
    check(refr_req == 0 && mf_refr_req == 0 && sig_freeze == 0 && err_cnt == 0,
          "R1 reset state", {refr_req, mf_refr_req, sig_freeze, err_cnt}, 0);
    @(negedge clk); rst_n = 1;
    resync();

    win_sel = 2'b00;
    send(1,0,1,1,0,0,"R2 e1"); send(0,0,3,1,0,0,"R2"); send(0,0,5,1,0,0,"R2");
    send(0,0,7,1,0,0,"R2");    send(1,0,9,1,0,0,"R2 2 apart by 4");
    send(0,0,11,1,0,0,"R2");   send(1,0,1,1,1,0,"R2 2 of 4 fires");
    send(1,0,3,0,0,0,"R9 ignored after reframe");
    resync();

    win_sel = 2'b01;
    send(1,0,1,1,0,0,"R3"); send(0,0,3,1,0,0,"R3"); send(0,0,5,1,0,0,"R3");
    send(0,0,7,1,0,0,"R3"); send(0,0,9,1,0,0,"R3");
    send(1,0,11,1,0,0,"R3 5 apart no fire");
    send(1,0,1,1,1,0,"R3 2 of 5 fires");
    resync();

    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0; exp_cnt = 0;
    check(err_cnt == 0, "R11 clear", err_cnt, 0);

    win_sel = 2'b10;
    send(1,0,1,1,0,0,"R4"); send(0,0,3,1,0,0,"R4"); send(0,0,5,1,0,0,"R4");
    send(0,0,7,1,0,0,"R4"); send(0,0,9,1,0,0,"R4");
    send(1,0,11,1,1,0,"R4 2 of 6 fires");
    resync();

    win_sel = 2'b11;
    for (int i = 0; i < 7; i++) send(1,0,1,1,0,0,"R5 R10 off counts, saturates");
    check(err_cnt == CMAX, "R10 ceiling", err_cnt, CMAX);
    host_reframe("R8 host reframe");
    resync();
    send(1,0,3,1,0,1,"R11 clear beats increment");
    host_reframe("R8 second host reframe");
    resync();

    win_sel = 2'b00; fs_incl = 0;
    send(1,1,2,0,0,0,"R6 Fs excluded"); send(1,1,4,0,0,0,"R6 Fs excluded");
    fs_incl = 1;
    send(1,1,2,1,0,0,"R6 Fs included");
    sec_yel = 1; send(1,1,12,0,0,0,"R6 frame 12 Fs excluded");
    sec_yel = 0; send(1,1,12,1,1,0,"R6 frame 12 Fs counted, fires");
    resync();

    fmt_esf = 1; send(1,1,4,0,0,0,"R7 ESF Fs ignored");
    fmt_esf = 0; fmt_slc = 1;
    send(1,1,2,0,0,0,"R7 SLC96 Fs ignored");
    send(1,0,1,1,0,0,"R6 Ft in SLC96"); send(1,0,3,1,1,0,"R6 Ft in SLC96 fires");
    resync();
    fmt_slc = 0;

    @(negedge clk); host_mfrefr = 1;
    @(negedge clk); host_mfrefr = 0;
    check(mf_refr_req == 1, "R12 mf request", mf_refr_req, 1);
    check(sig_freeze == 1, "R12 freeze set", sig_freeze, 1);
    check(refr_req == 0, "R12 no frame reframe", refr_req, 0);
    @(negedge clk);
    check(mf_refr_req == 0 && sig_freeze == 1, "R12 freeze held", {mf_refr_req, sig_freeze}, 1);
    mf_sync = 1;
    @(negedge clk); mf_sync = 0;
    check(sig_freeze == 0, "R12 freeze released", sig_freeze, 0);
    fmt_esf = 1;
    @(negedge clk); host_mfrefr = 1;
    @(negedge clk); host_mfrefr = 0;
    check(mf_refr_req == 0 && sig_freeze == 0, "R12 ESF ignores mf", {mf_refr_req, sig_freeze}, 0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule